// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This unit converts an accepted interrupt request into the 20-bit start address of its handler. It reads the four bytes of the request's vector through a byte-wide memory read port, one byte per cycle, and assembles the result. It then reports the handler address with a one-cycle completion pulse.

Two kinds of vector exist. Fixed vectors sit in a block of four-byte slots just below the top of the 20-bit address space. They are serviced regardless of the interrupt enable input. Variable vectors are 64 table entries placed relative to a table base input, and they are served only while interrupts are enabled. A break request reads its fixed slot first. If that slot holds all ones, the unit fetches a designated table entry instead. Requests that are masked or unknown are dropped with no memory traffic, and the unit stays ready for the next request.

Top module: `vec_fetch_unit`

## Requirements
- R1: Source codes 0 to 8 select fixed vectors whose first byte is at 0xFFFDC + 4*code. The codes are: 0 undefined opcode, 1 overflow trap, 2 break, 3 address match, 4 single step, 5 watchdog, 6 debug, 7 non-maskable pin, 8 reset.
- R2: A fixed-vector request is fetched whatever the value of `ien_i`.
- R3: Source code 9 is a software request. Its vector starts at `tbl_base_i + 4*swi_num_i`, truncated to 20 bits, and reads continue past the top of the address space by wrapping to 0.
- R4: A code-9 request while `ien_i` is 0 is dropped: no read strobe and no done pulse follow.
- R5: A code-3 request while `amatch_en_i` is 0 is dropped: no read strobe and no done pulse follow.
- R6: The four vector bytes are read at ascending addresses in four consecutive cycles with `mem_rd_o` high. Read data is taken from `mem_rdata_i` in the cycle after each strobe.
- R7: The handler address is byte0 in bits 7:0, byte1 in bits 15:8, and the low nibble of byte2 in bits 19:16. The high nibble of byte2 and all of byte3 are ignored.
- R8: `done_o` is high for exactly one cycle, the sixth cycle after the cycle in which `start_i` was high, and `handler_o` is valid in that cycle.
- R9: For a break request whose four fixed bytes are all 0xFF, the unit next fetches table entry `BRK_ENTRY` (default 0) at `tbl_base_i + 4*BRK_ENTRY`, whatever `ien_i` is. In that case `done_o` comes in the eleventh cycle after the start. If any of the 32 bits is 0, no second fetch takes place.
- R10: A start strobe that arrives while a fetch is in progress is ignored.
- R11: After reset `done_o` and `mem_rd_o` are 0 and `handler_o` is 0.
- R12: Source codes 10 to 15 are dropped with no read and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled only while idle |
| src_i | input | 4 | Source code of the request |
| swi_num_i | input | 6 | Software interrupt number |
| tbl_base_i | input | 20 | Variable table base address |
| ien_i | input | 1 | Interrupt enable flag |
| amatch_en_i | input | 1 | Enable for the address-match source |
| mem_rdata_i | input | 8 | Read data, one cycle after the strobe |
| mem_addr_o | output | 20 | Read address |
| mem_rd_o | output | 1 | Read strobe |
| handler_o | output | 20 | Assembled handler start address |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the break fallback. It needs memory contents in which the fixed break slot is exactly all ones. It must also be separated from a near miss in which only the top byte differs. The bench memory model has a mode that overrides the four break bytes with 0xFF, or with 0xFF except for 0xFE in the last byte. This exercises both the second fetch, including a table base that wraps past the top of memory, and the plain single fetch.

// File: rtl/vfu_pkg.sv
// Shared types for the interrupt vector fetch unit.
package vfu_pkg;
    // Source codes; fixed-vector codes are contiguous from zero.
    localparam logic [3:0] SRC_BRK    = 4'd2;
    localparam logic [3:0] SRC_AMATCH = 4'd3;
    localparam logic [3:0] SRC_LAST_FIXED = 4'd8;
    localparam logic [3:0] SRC_SOFT   = 4'd9;

    typedef enum logic {ST_IDLE, ST_FETCH} vfu_state_e;
endpackage

// File: rtl/vfu_vec_addr.sv
// Vector address generator: forms the first-byte address of the vector
// for the latched request. Assumes fixed slots are contiguous 4-byte
// slots starting at FIXED_BASE, indexed by the source code.
module vfu_vec_addr #(
    parameter int AW = 20,
    parameter int NUM_W = 6,
    parameter logic [AW-1:0] FIXED_BASE = 20'hFFFDC,
    parameter int BRK_ENTRY = 0
) (
    input  logic [3:0]       src_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [AW-1:0]    base_i,
    input  logic             use_fb_i,
    output logic [AW-1:0]    vec_addr_o,
    output logic             fixed_o,
    output logic             known_o
);
    import vfu_pkg::*;

    logic [NUM_W-1:0] var_num;
    logic [AW-1:0]    var_addr;
    logic [AW-1:0]    fix_addr;

    // Classify the source and pick the fixed or table-relative address.
    always_comb begin
        fixed_o    = (src_i <= SRC_LAST_FIXED);
        known_o    = fixed_o || (src_i == SRC_SOFT);
        var_num    = use_fb_i ? NUM_W'(BRK_ENTRY) : num_i;
        var_addr   = base_i + AW'({var_num, 2'b00});
        fix_addr   = FIXED_BASE + AW'({src_i, 2'b00});
        vec_addr_o = (fixed_o && !use_fb_i) ? fix_addr : var_addr;
    end
endmodule

// File: rtl/vfu_byte_asm.sv
// Byte assembler: shifts incoming bytes in from the top so that after
// NB captures the first byte sits in the lowest position. word_nxt_o
// exposes the value including the byte captured this cycle.
module vfu_byte_asm #(
    parameter int BW = 8,
    parameter int NB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             cap_i,
    input  logic [BW-1:0]    rdata_i,
    output logic [NB*BW-1:0] word_nxt_o
);
    localparam int WW = NB * BW;

    logic [WW-1:0] word_q;

    // Next word: shift the captured byte in at the top.
    always_comb begin
        word_nxt_o = cap_i ? {rdata_i, word_q[WW-1:BW]} : word_q;
    end

    // Hold the partial word between captures.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) word_q <= '0;
        else                 word_q <= word_nxt_o;
    end
endmodule

// File: rtl/vec_fetch_unit.sv
// Interrupt vector fetch unit: accepts a request while idle, screens it
// against the enable inputs, reads four vector bytes in ascending order
// (one-cycle read latency), handles the break fallback to the variable
// table, and pulses done with the handler address.
// Assumes AW <= NB*BW and that unused vector bits are don't-care.
module vec_fetch_unit #(
    parameter int AW = 20,
    parameter int BW = 8,
    parameter int NB = 4,
    parameter int NUM_W = 6,
    parameter logic [AW-1:0] FIXED_BASE = 20'hFFFDC,
    parameter int BRK_ENTRY = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       src_i,
    input  logic [NUM_W-1:0] swi_num_i,
    input  logic [AW-1:0]    tbl_base_i,
    input  logic             ien_i,
    input  logic             amatch_en_i,
    input  logic [BW-1:0]    mem_rdata_i,
    output logic [AW-1:0]    mem_addr_o,
    output logic             mem_rd_o,
    output logic [AW-1:0]    handler_o,
    output logic             done_o
);
    import vfu_pkg::*;

    localparam int STEP_W = $clog2(NB + 1);
    localparam int WW = NB * BW;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NB);

    vfu_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [3:0]        src_q;
    logic [NUM_W-1:0]  num_q;
    logic [AW-1:0]     base_q;
    logic              fb_q;
    logic [AW-1:0]     handler_q;
    logic              done_q;

    logic [AW-1:0]     vec_addr;
    logic              vec_fixed, vec_known;
    logic              req_fixed, req_known, req_ok;
    logic [WW-1:0]     word_nxt;
    logic              cap, clr, accept, last, go_fb;
    logic [AW-1:0]     dummy_addr;

    // Address for the latched request (or fallback entry).
    vfu_vec_addr #(.AW(AW), .NUM_W(NUM_W), .FIXED_BASE(FIXED_BASE),
                   .BRK_ENTRY(BRK_ENTRY)) u_addr (
        .src_i(src_q), .num_i(num_q), .base_i(base_q), .use_fb_i(fb_q),
        .vec_addr_o(vec_addr), .fixed_o(vec_fixed), .known_o(vec_known)
    );

    // Classification of the incoming request before it is latched.
    vfu_vec_addr #(.AW(AW), .NUM_W(NUM_W), .FIXED_BASE(FIXED_BASE),
                   .BRK_ENTRY(BRK_ENTRY)) u_class (
        .src_i(src_i), .num_i(swi_num_i), .base_i(tbl_base_i), .use_fb_i(1'b0),
        .vec_addr_o(dummy_addr), .fixed_o(req_fixed), .known_o(req_known)
    );

    // Byte capture and assembly.
    vfu_byte_asm #(.BW(BW), .NB(NB)) u_asm (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .cap_i(cap),
        .rdata_i(mem_rdata_i), .word_nxt_o(word_nxt)
    );

    // Request screening, strobes and fallback decision.
    always_comb begin
        req_ok = req_known &&
                 (req_fixed ? (src_i != SRC_AMATCH || amatch_en_i) : ien_i);
        accept = (state_q == ST_IDLE) && start_i && req_ok;
        mem_rd_o   = (state_q == ST_FETCH) && (step_q < LAST_STEP);
        mem_addr_o = vec_addr + AW'(step_q);
        cap    = (state_q == ST_FETCH) && (step_q != '0);
        last   = (state_q == ST_FETCH) && (step_q == LAST_STEP);
        go_fb  = last && (src_q == SRC_BRK) && !fb_q && (word_nxt == '1);
        clr    = accept || go_fb;
        handler_o = handler_q;
        done_o    = done_q;
    end

    // Sequencer: idle/fetch state, step count and request latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            step_q    <= '0;
            src_q     <= '0;
            num_q     <= '0;
            base_q    <= '0;
            fb_q      <= 1'b0;
            handler_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_FETCH;
                step_q  <= '0;
                src_q   <= src_i;
                num_q   <= swi_num_i;
                base_q  <= tbl_base_i;
                fb_q    <= 1'b0;
            end else if (go_fb) begin
                fb_q   <= 1'b1;
                step_q <= '0;
            end else if (last) begin
                state_q   <= ST_IDLE;
                handler_q <= word_nxt[AW-1:0];
                done_q    <= 1'b1;
            end else if (state_q == ST_FETCH) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_MASKED_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && src_i == SRC_SOFT && !ien_i) |=> !mem_rd_o); // R4
    AST_AMATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && src_i == SRC_AMATCH && !amatch_en_i) |=> !mem_rd_o); // R5
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o) && step_q != '0) |-> mem_addr_o == $past(mem_addr_o) + 1'b1); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && step_q != LAST_STEP) |=> (state_q == ST_FETCH)); // R10
    AST_NO_DONE_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && src_i > SRC_SOFT) |=> !mem_rd_o); // R12
endmodule

// File: tb/sim_vec_fetch_unit.sv
module sim_vec_fetch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  src_i = '0;
    logic [5:0]  swi_num_i = '0;
    logic [19:0] tbl_base_i = '0;
    logic        ien_i = 1'b0;
    logic        amatch_en_i = 1'b0;
    logic [7:0]  mem_rdata_i = '0;
    logic [19:0] mem_addr_o;
    logic        mem_rd_o;
    logic [19:0] handler_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;
    int cur_ffm = 0;
    int rd_count = 0;
    logic [19:0] last_start = '0;
    logic        prev_rd = 1'b0;
    logic [19:0] prev_addr = '0;
    int cycles = 0;

    always #10 clk = ~clk;

    vec_fetch_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i),
        .swi_num_i(swi_num_i), .tbl_base_i(tbl_base_i), .ien_i(ien_i),
        .amatch_en_i(amatch_en_i), .mem_rdata_i(mem_rdata_i),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
        .handler_o(handler_o), .done_o(done_o)
    );

    // Memory contents; ffm 1 fills the break slot with FF, ffm 2 all FF but FE at top.
    function automatic logic [7:0] mbyte(logic [19:0] a, int ffm);
        if (ffm != 0 && a >= 20'hFFFE4 && a <= 20'hFFFE7)
            return (ffm == 2 && a == 20'hFFFE7) ? 8'hFE : 8'hFF;
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h3C;
    endfunction

    function automatic logic [19:0] ref_handler(logic [19:0] a, int ffm);
        logic [7:0] b0, b1, b2;
        b0 = mbyte(a, ffm);
        b1 = mbyte(a + 20'd1, ffm);
        b2 = mbyte(a + 20'd2, ffm);
        return {b2[3:0], b1, b0};
    endfunction

    // Memory model: one-cycle read latency.
    always @(posedge clk) begin
        mem_rdata_i <= mem_rd_o ? mbyte(mem_addr_o, cur_ffm) : 8'h00;
    end

    // Read monitor sampled away from the edge: counts strobes, checks order (R6).
    always @(negedge clk) begin
        if (rst_n && mem_rd_o) begin
            rd_count++;
            if (!prev_rd) last_start = mem_addr_o;
            else begin
                n_chk++;
                if (mem_addr_o != prev_addr + 20'd1) begin
                    n_fail++;
                    $display("FAIL R6 read order: act %h exp %h", mem_addr_o, prev_addr + 20'd1);
                end
            end
        end
        prev_rd   = rst_n && mem_rd_o;
        prev_addr = mem_addr_o;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: act %0d cycles exp under 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    // Issue one request; report cycle of first done (0 if none in 16), done count, handler.
    task automatic run(input logic [3:0] s, input logic [5:0] n, input logic [19:0] b,
                       input logic ie, input logic am, input int ffm,
                       output int lat, output int ndone, output logic [19:0] h);
        @(negedge clk);
        cur_ffm = ffm;
        src_i = s; swi_num_i = n; tbl_base_i = b; ien_i = ie; amatch_en_i = am;
        start_i = 1'b1;
        rd_count = 0;
        lat = 0; ndone = 0; h = '0;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) begin
                ndone++;
                if (lat == 0) begin lat = k; h = handler_o; end
            end
        end
    endtask

    // Vector table: {src, num, base, ien, amatch_en, ffm, exp_addr, exp_latency}
    localparam int NV = 17;
    localparam logic [57:0] TBL [0:NV-1] = '{
        {4'd0, 6'd0,  20'h00000, 1'b0, 1'b0, 2'd0, 20'hFFFDC, 4'd6},  // R1 R2
        {4'd1, 6'd0,  20'h00000, 1'b1, 1'b0, 2'd0, 20'hFFFE0, 4'd6},  // R1
        {4'd3, 6'd0,  20'h00000, 1'b0, 1'b1, 2'd0, 20'hFFFE8, 4'd6},  // R1 R5
        {4'd3, 6'd0,  20'h00000, 1'b1, 1'b0, 2'd0, 20'h00000, 4'd0},  // R5
        {4'd4, 6'd0,  20'h00000, 1'b0, 1'b0, 2'd0, 20'hFFFEC, 4'd6},  // R1
        {4'd5, 6'd0,  20'h00000, 1'b1, 1'b0, 2'd0, 20'hFFFF0, 4'd6},  // R1
        {4'd6, 6'd0,  20'h00000, 1'b0, 1'b0, 2'd0, 20'hFFFF4, 4'd6},  // R1
        {4'd7, 6'd0,  20'h00000, 1'b0, 1'b0, 2'd0, 20'hFFFF8, 4'd6},  // R1 R2
        {4'd8, 6'd0,  20'h00000, 1'b0, 1'b0, 2'd0, 20'hFFFFC, 4'd6},  // R1
        {4'd9, 6'd5,  20'h10000, 1'b1, 1'b0, 2'd0, 20'h10014, 4'd6},  // R3
        {4'd9, 6'd63, 20'hFFF80, 1'b1, 1'b0, 2'd0, 20'h0007C, 4'd6},  // R3 wrap
        {4'd9, 6'd7,  20'h10000, 1'b0, 1'b0, 2'd0, 20'h00000, 4'd0},  // R4
        {4'd12,6'd0,  20'h00000, 1'b1, 1'b1, 2'd0, 20'h00000, 4'd0},  // R12
        {4'd2, 6'd0,  20'h20000, 1'b0, 1'b0, 2'd0, 20'hFFFE4, 4'd6},  // R1 R9
        {4'd2, 6'd9,  20'h20000, 1'b0, 1'b0, 2'd1, 20'h20000, 4'd11}, // R9
        {4'd2, 6'd0,  20'h20000, 1'b1, 1'b0, 2'd2, 20'hFFFE4, 4'd6},  // R9 near miss
        {4'd2, 6'd0,  20'hFFFFE, 1'b1, 1'b0, 2'd1, 20'hFFFFE, 4'd11}  // R9 R3 wrap
    };

    initial begin
        int lat, nd;
        logic [19:0] h;
        // R11: reset state.
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0, "R11 done", 32'(done_o), 32'd0);
        chk(mem_rd_o == 1'b0, "R11 rd", 32'(mem_rd_o), 32'd0);
        chk(handler_o == 20'd0, "R11 handler", 32'(handler_o), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [57:0] v;
            v = TBL[i];
            run(v[57:54], v[53:48], v[47:28], v[27], v[26], int'(v[25:24]), lat, nd, h);
            chk(lat == int'(v[3:0]), $sformatf("R8/R4/R5/R9/R12 latency vec %0d", i), 32'(lat), 32'(v[3:0]));
            if (v[3:0] == 4'd0) begin
                chk(rd_count == 0, $sformatf("R4/R5/R12 no read vec %0d", i), 32'(rd_count), 32'd0);
            end else begin
                chk(nd == 1, $sformatf("R8 single pulse vec %0d", i), 32'(nd), 32'd1);
                chk(last_start == v[23:4], $sformatf("R1/R3/R9 vector address vec %0d", i), 32'(last_start), 32'(v[23:4]));
                chk(h == ref_handler(v[23:4], int'(v[25:24])), $sformatf("R7 handler vec %0d", i),
                    32'(h), 32'(ref_handler(v[23:4], int'(v[25:24]))));
                chk(rd_count == ((v[3:0] == 4'd11) ? 8 : 4), $sformatf("R6/R9 read count vec %0d", i),
                    32'(rd_count), (v[3:0] == 4'd11) ? 32'd8 : 32'd4);
            end
        end

        // R10: a second start during a fetch is ignored.
        @(negedge clk);
        cur_ffm = 0;
        src_i = 4'd0; ien_i = 1'b0; start_i = 1'b1; rd_count = 0;
        lat = 0; nd = 0; h = '0;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            start_i = (k == 2);
            if (k == 2) src_i = 4'd8;
            if (done_o) begin nd++; if (lat == 0) begin lat = k; h = handler_o; end end
        end
        chk(lat == 6, "R10 latency", 32'(lat), 32'd6);
        chk(nd == 1, "R10 one done", 32'(nd), 32'd1);
        chk(h == ref_handler(20'hFFFDC, 0), "R10 handler", 32'(h), 32'(ref_handler(20'hFFFDC, 0)));
        chk(rd_count == 4, "R10 read count", 32'(rd_count), 32'd4);

        // R11: reset mid-fetch returns outputs to idle values.
        @(negedge clk);
        src_i = 4'd1; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(mem_rd_o == 1'b0, "R11 rd after reset", 32'(mem_rd_o), 32'd0);
        chk(handler_o == 20'd0, "R11 handler after reset", 32'(handler_o), 32'd0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(done_o == 1'b0, "R11 no late done", 32'(done_o), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule